// File: doc/BRIEF.md
# Display Register Write Sequencer

This block takes one register write request at a time, an 8-bit register index with a 16-bit value, over a valid/ready handshake. It delivers the write to an external display controller as two separate serial transfers on a write-only four-wire serial link. The first transfer selects the register: a selector byte `0x70`, a zero byte, then the index. The second transfer carries the contents: a selector byte `0x72`, then the value's high byte, then its low byte.

The serial link runs in mode 3. The clock idles high, data changes on the falling edge and is sampled on the rising edge, and each byte goes out most significant bit first. Chip select rises between the two transfers, and stays high for at least one serial clock period after each one. The block raises `done` for one cycle when both transfers are over. The serial clock half period is a parameter counted in system clock cycles.

Top module: `disp_reg_writer`

## Requirements
- R1: The first chip-select-low window of a write carries exactly 24 bits, MSB first: `0x70`, `0x00`, then the 8-bit register index.
- R2: The second chip-select-low window of a write carries exactly 24 bits, MSB first: `0x72`, the value bits 15..8, then the value bits 7..0.
- R3: For one write, the index transfer ends (chip select high) before the data transfer begins, and the serial clock toggles only while chip select is low.
- R4: The serial clock is high whenever chip select changes and while idle. The data line is stable during every high phase of the serial clock inside a transfer.
- R5: Chip select stays high for at least 2*CLK_DIV system cycles (one serial clock period) between the two transfers, and between the rise after the second transfer and `done`.
- R6: `req_ready` is high only while no write is in progress. A request is taken only when `req_valid` and `req_ready` are both high. Index and value are captured on acceptance, so later changes on the request inputs do not alter the transfers in progress. With `req_valid` low, no transfer starts.
- R7: `done` is a single-cycle pulse after both transfers. `req_ready` is high in that same cycle.
- R8: A synchronous active-high reset, including one in the middle of a transfer, leaves chip select high, the serial clock high, `done` low and `req_ready` high.
- R9: Each low phase of the serial clock inside a transfer lasts exactly CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_index | input | 8 | Register index to write |
| req_value | input | 16 | Register value to write |
| done | output | 1 | One-cycle pulse when the write is finished |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench decodes the serial link on its own by sampling the data line on rising clock edges while chip select is low, and compares each captured 24-bit window with the frame formats. Several index and value patterns are used: all zeros, all ones, alternating bits, and patterns whose selector and payload differ. A design that swapped bit order or the selector bytes, or that merged the two transfers under one chip select, would show wrong window contents or a window count other than two. The bench scrambles the request inputs right after acceptance, holds `req_valid` low for a long stretch, and resets in the middle of a transfer. These steps catch a design that fails to latch its request, starts without a handshake, or comes out of reset with chip select or the serial clock at the wrong level. Measured chip-select gaps and serial clock low phases catch a divider off by one or a missing inter-transfer gap.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;
  localparam int IDX_W   = 8;
  localparam int VAL_W   = 16;
  localparam int FRAME_W = 24;
  localparam logic [7:0] SEL_INDEX = 8'h70;
  localparam logic [7:0] SEL_DATA  = 8'h72;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_BITS, E_HOLD} eng_st_t;
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_GAP} seq_st_t;

  function automatic logic [FRAME_W-1:0] index_frame(input logic [IDX_W-1:0] idx);
    return {SEL_INDEX, 8'h00, idx};
  endfunction

  function automatic logic [FRAME_W-1:0] data_frame(input logic [VAL_W-1:0] val);
    return {SEL_DATA, val};
  endfunction
endpackage

// File: rtl/drw_tick_gen.sv
module drw_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/drw_bit_engine.sv
module drw_bit_engine
  import disp_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               busy,
  output logic               fin
);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  eng_st_t            st;
  logic [FRAME_W-1:0] sh;
  logic [BW-1:0]      bcnt;

  assign busy = (st != E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= E_IDLE;
      sclk <= 1'b1;
      cs_n <= 1'b1;
      mosi <= 1'b0;
      sh   <= '0;
      bcnt <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          st   <= E_SETUP;
          cs_n <= 1'b0;
          sh   <= frame;
          bcnt <= '0;
        end
        E_SETUP: if (tick) begin
          st   <= E_BITS;
          sclk <= 1'b0;
          mosi <= sh[FRAME_W-1];
          sh   <= sh << 1;
        end
        E_BITS: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else if (bcnt == LAST_BIT) begin
            st <= E_HOLD;
          end else begin
            sclk <= 1'b0;
            mosi <= sh[FRAME_W-1];
            sh   <= sh << 1;
            bcnt <= bcnt + 1'b1;
          end
        end
        E_HOLD: if (tick) begin
          cs_n <= 1'b1;
          fin  <= 1'b1;
          st   <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drw_seq.sv
module drw_seq
  import disp_reg_pkg::*;
#(
  parameter int GAP_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [VAL_W-1:0]   req_value,
  input  logic               fin,
  output logic               req_ready,
  output logic               accept,
  output logic               start,
  output logic [FRAME_W-1:0] frame,
  output logic               gap_busy,
  output logic               done,
  output logic [IDX_W-1:0]   held_index,
  output logic [VAL_W-1:0]   held_value
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

  seq_st_t       st;
  logic          data_phase;
  logic [GW-1:0] gcnt;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = (st == S_LAUNCH);
  assign gap_busy  = (st == S_GAP);
  assign frame     = data_phase ? data_frame(held_value) : index_frame(held_index);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      data_phase <= 1'b0;
      gcnt       <= '0;
      done       <= 1'b0;
      held_index <= '0;
      held_value <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          held_index <= req_index;
          held_value <= req_value;
          data_phase <= 1'b0;
          st         <= S_LAUNCH;
        end
        S_LAUNCH: st <= S_WAIT;
        S_WAIT: if (fin) begin
          gcnt <= '0;
          st   <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (gcnt == GAP_LAST) begin
            if (!data_phase) begin
              data_phase <= 1'b1;
              st         <= S_LAUNCH;
            end else begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/disp_reg_writer.sv
module disp_reg_writer
  import disp_reg_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int GAP_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_index,
  input  logic [15:0] req_value,
  output logic        done,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n
);
  logic               tick;
  logic               accept;
  logic               start;
  logic               fin;
  logic               eng_busy;
  logic               gap_busy;
  logic               div_en;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   held_index;
  logic [VAL_W-1:0]   held_value;

  assign div_en = eng_busy || gap_busy;

  drw_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (div_en),
    .tick(tick)
  );

  drw_seq #(.GAP_TICKS(GAP_TICKS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req_valid (req_valid),
    .req_index (req_index),
    .req_value (req_value),
    .fin       (fin),
    .req_ready (req_ready),
    .accept    (accept),
    .start     (start),
    .frame     (frame),
    .gap_busy  (gap_busy),
    .done      (done),
    .held_index(held_index),
    .held_value(held_value)
  );

  drw_bit_engine u_eng (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .start(start),
    .frame(frame),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .cs_n (spi_cs_n),
    .busy (eng_busy),
    .fin  (fin)
  );
endmodule

// File: rtl/disp_reg_writer_chk.sv
module disp_reg_writer_chk #(
  parameter int CLK_DIV = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        done,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        spi_cs_n,
  input logic        tick,
  input logic        accept,
  input logic [7:0]  held_index,
  input logic [15:0] held_value
);
  localparam logic [15:0] MIN_GAP = 16'(2 * CLK_DIV);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  hi_cnt <= '1;
    else if (!spi_cs_n)       hi_cnt <= '0;
    else if (hi_cnt != '1)    hi_cnt <= hi_cnt + 1'b1;
  end

  // R4
  cs_edge_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> spi_sclk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk) && !spi_cs_n && !$past(spi_cs_n)) |-> $stable(spi_mosi));

  // R3
  sclk_only_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_sclk) |-> !spi_cs_n);

  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= MIN_GAP));

  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (spi_cs_n && !tick));

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(accept)) |-> ($stable(held_index) && $stable(held_value)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && spi_cs_n && hi_cnt >= MIN_GAP));
endmodule

bind disp_reg_writer disp_reg_writer_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n),
  .tick      (tick),
  .accept    (accept),
  .held_index(held_index),
  .held_value(held_value)
);

// File: tb/disp_reg_writer_bench.sv
`timescale 1ns/1ps
module disp_reg_writer_bench;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_index = 8'h00;
  logic [15:0] req_value = 16'h0000;
  logic        done;
  logic        spi_sclk, spi_mosi, spi_cs_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  disp_reg_writer #(.CLK_DIV(DIV), .GAP_TICKS(2)) u_disp_reg_writer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_value(req_value), .done(done),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  // independent link monitor
  int          cyc = 0;
  logic [23:0] cap;
  int          nbits;
  int          nwin;
  logic [23:0] win_data [4];
  int          win_bits [4];
  int          rise_cyc [4];
  int          fall_cyc [4];
  int          nrise, nfall;
  int          last_fall;
  int          bad_len, bad_edge;

  always @(posedge clk) cyc++;

  task automatic mon_clear();
    nwin = 0; nrise = 0; nfall = 0; nbits = 0; cap = '0;
    bad_len = 0; bad_edge = 0; last_fall = -1;
  endtask

  always @(negedge spi_cs_n) begin
    if (spi_sclk !== 1'b1) bad_edge++;
    nbits = 0; cap = '0; last_fall = -1;
    if (nfall < 4) begin fall_cyc[nfall] = cyc; nfall++; end
  end

  always @(posedge spi_cs_n) begin
    if (spi_sclk !== 1'b1) bad_edge++;
    if (nwin < 4) begin
      win_data[nwin] = cap; win_bits[nwin] = nbits; rise_cyc[nwin] = cyc; nwin++;
    end
    nrise++;
  end

  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) last_fall = cyc;

  always @(posedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      cap = {cap[22:0], spi_mosi};
      nbits++;
      if (last_fall < 0 || (cyc - last_fall) != DIV) bad_len++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mon_clear();
  endtask

  // issue one write, scramble inputs after acceptance, wait for done
  task automatic do_write(input logic [7:0] idx, input logic [15:0] val, output int done_cyc);
    int seen;
    int waitc;
    seen = 0; done_cyc = -1;
    mon_clear();
    while (!req_ready) @(negedge clk);
    req_index = idx; req_value = val; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_index = ~idx; req_value = ~val;
    chk(req_ready == 1'b0, "R6 ready low while busy", req_ready, 0);
    waitc = 0;
    while (seen == 0 && waitc < 3000) begin
      @(negedge clk);
      waitc++;
      if (!spi_cs_n && req_ready) chk(0, "R6 ready high during transfer", 1, 0);
      if (done) begin seen = 1; done_cyc = cyc; end
    end
    chk(seen == 1, "R7 done observed", seen, 1);
    chk(req_ready == 1'b1, "R7 ready with done", req_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  task automatic check_write(input logic [7:0] idx, input logic [15:0] val);
    int dc;
    do_write(idx, val, dc);
    chk(nwin == 2, "R3 two windows", nwin, 2);
    if (nwin == 2) begin
      chk(win_bits[0] == 24, "R1 index bit count", win_bits[0], 24);
      chk(win_data[0] == {8'h70, 8'h00, idx}, "R1 index frame", win_data[0], {8'h70, 8'h00, idx});
      chk(win_bits[1] == 24, "R2 data bit count", win_bits[1], 24);
      chk(win_data[1] == {8'h72, val}, "R2 data frame", win_data[1], {8'h72, val});
      chk(fall_cyc[1] > rise_cyc[0], "R3 index ends before data", fall_cyc[1], rise_cyc[0]);
      chk(fall_cyc[1] - rise_cyc[0] >= 2*DIV, "R5 gap between transfers", fall_cyc[1] - rise_cyc[0], 2*DIV);
      chk(dc - rise_cyc[1] >= 2*DIV, "R5 gap before done", dc - rise_cyc[1], 2*DIV);
    end
    chk(bad_len == 0, "R9 low phase length", bad_len, 0);
    chk(bad_edge == 0, "R4 sclk high at cs edges", bad_edge, 0);
    chk(spi_sclk == 1'b1 && spi_cs_n == 1'b1, "R4 idle levels", {spi_sclk, spi_cs_n}, 2'b11);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(spi_cs_n == 1'b1, "R8 cs high after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R8 sclk high after reset", spi_sclk, 1);
    chk(done == 1'b0, "R8 done low after reset", done, 0);
    chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
  endtask

  task automatic t_patterns();
    check_write(8'h22, 16'h1234);
    check_write(8'h00, 16'h0000);
    check_write(8'hFF, 16'hFFFF);
    check_write(8'hA5, 16'h5AA5);
    check_write(8'h70, 16'h7270);
  endtask

  task automatic t_no_valid();
    mon_clear();
    req_valid = 1'b0; req_index = 8'h3C; req_value = 16'hBEEF;
    repeat (100) @(negedge clk);
    chk(nfall == 0, "R6 no transfer without valid", nfall, 0);
    chk(req_ready == 1'b1, "R6 ready stays high", req_ready, 1);
  endtask

  task automatic t_reset_mid();
    mon_clear();
    req_index = 8'h11; req_value = 16'h2233; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b0, "R8 transfer under way before reset", spi_cs_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b1, "R8 mid-transfer reset levels", {spi_cs_n, spi_sclk}, 2'b11);
    chk(req_ready == 1'b1 && done == 1'b0, "R8 mid-transfer reset handshake", {req_ready, done}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check_write(8'h5A, 16'hC3C3);
  endtask

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_patterns();
    t_no_valid();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule